// File: doc/BRIEF.md
# Watchdog Timer with Safe-Frequency Fallback

This block watches for periodic proof of life from system software and recovers the system when that proof stops. A programmable 8-bit reload value sets the timeout as a whole number of fixed time units of 290 ms each. A prescaler derives the unit from the input clock. Software restarts the countdown with a kick pulse. Any write of a new reload value also restarts it.

When the countdown runs out, three things happen together. A sticky alarm flag is raised. The 5-bit frequency-select code sent to the clock synthesizer is replaced by a programmed safe code. An active-low system reset is pulsed for a fixed number of clock cycles.

The same reset pulse is produced whenever the frequency-select output changes, for example when software programs a new gear ratio. A program-enable control chooses where the frequency code and the watchdog enable come from. While it is clear, they come from strap inputs. While it is set, they come from software fields. The synthesizer itself lies outside the block: the block only drives the code and an indication of where the code came from.

Top module: `wdog_freq_guard`

## Requirements
- R1: After reset the reload value is 16, the alarm is 0, program-enable is 0, `fsel` equals `strap_fsel`, `fsel_src` is 0 (strap), and `sys_rst_n` is 1.
- R2: Once running, the alarm rises exactly max(N,1)*TICK_DIV clock edges after the edge that started the count, where N is the reload value. The count starts with a kick, a reload write, an enable write, or an enable input that is already high before the first edge. A reload value of 0 behaves as 1.
- R3: With the power-up reload value of 16 and the strap enable high, the first timeout comes 16 units after reset.
- R4: A kick reloads the countdown and clears the prescaler, so the timeout is measured afresh from the kick edge.
- R5: A write to the reload register sets the new value and restarts the countdown from it at once.
- R6: While program-enable is 0, the watchdog runs only when `strap_wd_en` is 1, and `ctl_wd_en` has no effect. While program-enable is 1, only `ctl_wd_en` decides and the strap enable has no effect. A disabled watchdog never raises the alarm.
- R7: The alarm is sticky. Kicks do not clear it, and a control write with `ctl_alarm`=1 leaves it set. Only a control write with `ctl_alarm`=0 clears it.
- R8: The frequency-select source follows a fixed priority. When the alarm is set, the output is the safe code with `fsel_src`=2. Otherwise, when program-enable is set, it is the frequency register with `fsel_src`=1. Otherwise it is `strap_fsel` with `fsel_src`=0.
- R9: On expiry, `sys_rst_n` goes low in the cycle after the expiry edge and stays low for exactly RST_CYCLES cycles. A trigger that comes while the pulse is active does not extend it.
- R10: Any change of the `fsel` output after reset causes the same reset pulse, starting one cycle after the change. A write that leaves `fsel` unchanged causes no pulse.
- R11: While the alarm is set, the countdown is halted and no further expiry or reset pulse comes from the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_wd_en | input | 1 | Strap-latched watchdog enable |
| strap_fsel | input | 5 | Strap-latched frequency-select code |
| kick | input | 1 | Software kick pulse; restarts the countdown |
| cnt_wr | input | 1 | Write strobe for the reload register |
| cnt_wdata | input | 8 | Reload value in 290 ms units |
| ctl_wr | input | 1 | Write strobe for the control fields |
| ctl_prog_en | input | 1 | Program-enable value |
| ctl_wd_en | input | 1 | Software watchdog enable value |
| ctl_alarm | input | 1 | Alarm field; 0 clears the alarm, 1 leaves it unchanged |
| ctl_safe | input | 5 | Safe frequency-select code |
| frq_wr | input | 1 | Write strobe for the frequency register |
| frq_wdata | input | 5 | Software frequency-select code |
| fsel | output | 5 | Active frequency-select code |
| fsel_src | output | 2 | Source of the code: 0 strap, 1 register, 2 safe |
| alarm | output | 1 | Sticky watchdog alarm status |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The timeout is swept over several reload values, including 0, 1 and the power-up value of 16. The bench counts edges to the alarm and compares the count with max(N,1)*TICK_DIV, which tells an off-by-one in the prescaler apart from one in the unit counter. Kicks and reload writes are issued in the middle of a countdown, which separates a restart that clears the prescaler from one that only reloads the unit count. Each enable source is tried while the other one holds the opposite value. Frequency-register writes are issued with a new value, with the same value, and back to back, which separates a change-driven pulse from a write-driven pulse and shows whether a second trigger stretches the pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    SRC_STRAP = 2'd0,
    SRC_REG   = 2'd1,
    SRC_SAFE  = 2'd2
  } fsel_src_e;

  // Timeout in clock cycles for a reload value; zero is treated as one unit.
  function automatic longint unsigned units_to_cycles(input logic [7:0] n,
                                                      input longint unsigned div);
    longint unsigned u;
    u = (n == 8'd0) ? 1 : longint'(n);
    return u * div;
  endfunction

  // Priority of the frequency-select source.
  function automatic fsel_src_e pick_src(input logic alarm_set, input logic prog_on);
    if (alarm_set)    return SRC_SAFE;
    else if (prog_on) return SRC_REG;
    else              return SRC_STRAP;
  endfunction

  // Next value of the remaining-unit counter on a prescaler tick.
  function automatic logic [7:0] unit_step(input logic [7:0] rem);
    return (rem == 8'd0) ? 8'd0 : rem - 8'd1;
  endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter longint unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && !restart && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (restart || !run)   pre_q <= '0;
    else if (pre_q == LAST)     pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> (pre_q == $past(pre_q) + 1'b1));

  // R4
  pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));

endmodule

// File: rtl/wdg_unit_count.sv
module wdg_unit_count
  import wdg_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  RESET_VAL = 8'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);
  logic [CNT_W-1:0] rem_q;

  assign expire = run && tick && !reload && (rem_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rem_q <= CNT_W'(RESET_VAL);
    else if (reload || !run)  rem_q <= reload_val;
    else if (tick)            rem_q <= CNT_W'(unit_step(8'(rem_q)));
  end

  // R2
  unit_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !reload && rem_q > CNT_W'(1)) |=> (rem_q == $past(rem_q) - 1'b1));

  // R5
  unit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (rem_q == $past(reload_val)));

endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic rst_out_n
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] cnt_q;

  assign rst_out_n = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (trigger && cnt_q == '0)   cnt_q <= CW'(WIDTH);
    else if (cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
  end

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CW'(1)) |=> !rst_out_n);

endmodule

// File: rtl/wdog_freq_guard.sv
module wdog_freq_guard
  import wdg_pkg::*;
#(
  parameter longint unsigned CLK_HZ        = 50_000_000,
  parameter longint unsigned UNIT_MS       = 290,
  parameter longint unsigned TICK_DIV      = CLK_HZ / 1000 * UNIT_MS,
  parameter int              RST_CYCLES    = 16,
  parameter int              FSEL_W        = 5,
  parameter logic [7:0]      COUNT_DEFAULT = 8'd16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_wd_en,
  input  logic [FSEL_W-1:0] strap_fsel,
  input  logic              kick,
  input  logic              cnt_wr,
  input  logic [7:0]        cnt_wdata,
  input  logic              ctl_wr,
  input  logic              ctl_prog_en,
  input  logic              ctl_wd_en,
  input  logic              ctl_alarm,
  input  logic [FSEL_W-1:0] ctl_safe,
  input  logic              frq_wr,
  input  logic [FSEL_W-1:0] frq_wdata,
  output logic [FSEL_W-1:0] fsel,
  output logic [1:0]        fsel_src,
  output logic              alarm,
  output logic              sys_rst_n
);
  logic [7:0]        count_q;
  logic              prog_en_q, wd_en_q, alarm_q, primed_q;
  logic [FSEL_W-1:0] safe_q, freq_q, prev_fsel_q;

  logic              wd_enabled, wd_run, restart, tick, expire, fsel_change;
  logic [7:0]        reload_val;
  fsel_src_e         src;

  assign wd_enabled = prog_en_q ? wd_en_q : strap_wd_en;
  assign wd_run     = wd_enabled && !alarm_q;
  assign restart    = kick || cnt_wr;
  assign reload_val = cnt_wr ? cnt_wdata : count_q;

  wdg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(wd_run), .restart(restart), .tick(tick)
  );

  wdg_unit_count #(.CNT_W(8), .RESET_VAL(COUNT_DEFAULT)) u_units (
    .clk(clk), .rst_n(rst_n), .run(wd_run), .tick(tick),
    .reload(restart), .reload_val(reload_val), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= COUNT_DEFAULT;
      prog_en_q <= 1'b0;
      wd_en_q   <= 1'b0;
      safe_q    <= '0;
      freq_q    <= '0;
    end else begin
      if (cnt_wr) count_q <= cnt_wdata;
      if (ctl_wr) begin
        prog_en_q <= ctl_prog_en;
        wd_en_q   <= ctl_wd_en;
        safe_q    <= ctl_safe;
      end
      if (frq_wr) freq_q <= frq_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     alarm_q <= 1'b0;
    else if (expire)                alarm_q <= 1'b1;
    else if (ctl_wr && !ctl_alarm)  alarm_q <= 1'b0;
  end

  assign src = pick_src(alarm_q, prog_en_q);

  always_comb begin
    case (src)
      SRC_SAFE: fsel = safe_q;
      SRC_REG:  fsel = freq_q;
      default:  fsel = strap_fsel;
    endcase
  end

  assign fsel_src = src;
  assign alarm    = alarm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      prev_fsel_q <= '0;
    end else begin
      primed_q    <= 1'b1;
      prev_fsel_q <= fsel;
    end
  end

  assign fsel_change = primed_q && (fsel != prev_fsel_q);

  wdg_rst_stretch #(.WIDTH(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(expire || fsel_change), .rst_out_n(sys_rst_n)
  );

  // R7
  alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(expire));

  // R10
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> $past(expire || fsel_change));

  // R11
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> !expire);

  // R8
  safe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> (fsel == safe_q));

endmodule

// File: tb/sim_wdog_freq_guard.sv
module sim_wdog_freq_guard;
  localparam int DIV = 4;
  localparam int RST = 3;
  localparam logic [4:0] STRAP = 5'h0A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_wd_en = 1'b0;
  logic [4:0] strap_fsel = STRAP;
  logic kick = 1'b0, cnt_wr = 1'b0, ctl_wr = 1'b0, frq_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic ctl_prog_en = 1'b0, ctl_wd_en = 1'b0, ctl_alarm = 1'b0;
  logic [4:0] ctl_safe = '0, frq_wdata = '0;
  logic [4:0] fsel;
  logic [1:0] fsel_src;
  logic alarm, sys_rst_n;

  int vectors = 0;
  int miss = 0;

  always #10 clk = ~clk;

  wdog_freq_guard #(.TICK_DIV(DIV), .RST_CYCLES(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_wd_en(strap_wd_en), .strap_fsel(strap_fsel),
    .kick(kick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ctl_wr(ctl_wr), .ctl_prog_en(ctl_prog_en), .ctl_wd_en(ctl_wd_en),
    .ctl_alarm(ctl_alarm), .ctl_safe(ctl_safe),
    .frq_wr(frq_wr), .frq_wdata(frq_wdata),
    .fsel(fsel), .fsel_src(fsel_src), .alarm(alarm), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
  endtask

  task automatic wr_ctl(input logic pe, input logic we, input logic al, input logic [4:0] sf);
    ctl_prog_en = pe; ctl_wd_en = we; ctl_alarm = al; ctl_safe = sf; ctl_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] n);
    cnt_wdata = n; cnt_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic wr_frq(input logic [4:0] f);
    frq_wdata = f; frq_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    frq_wr = 1'b0;
  endtask

  task automatic do_kick;
    kick = 1'b1;
    @(posedge clk); @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_alarm(input int limit, output int n);
    n = 0;
    while (!alarm && n < limit) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!sys_rst_n && n < 100) begin
      n++; @(negedge clk);
    end
  endtask

  task automatic idle;
    repeat (RST + 3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary;
    $finish;
  end

  int n, w, hi;
  int ns[6] = '{1, 2, 3, 5, 9, 0};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fsel", fsel, STRAP);
    chk("R1 fsel_src", fsel_src, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 sys_rst_n", sys_rst_n, 1);

    // R3 default reload 16 units via strap enable
    strap_wd_en = 1'b1;
    wait_alarm(1000, n);
    chk("R3 default timeout", n, 16 * DIV);
    // R8 safe code takes over
    chk("R8 fsel safe", fsel, 0);
    chk("R8 src safe", fsel_src, 2);
    // R9 pulse width
    chk("R9 pulse starts", sys_rst_n, 0);
    measure_low(w);
    chk("R9 pulse width", w, RST);

    // R11 halted while alarmed
    hi = 1;
    repeat (30 * DIV) begin
      @(negedge clk);
      if (!sys_rst_n || !alarm) hi = 0;
    end
    chk("R11 no further pulse", hi, 1);

    // R7 sticky alarm
    strap_wd_en = 1'b0;
    wr_ctl(1'b0, 1'b0, 1'b1, 5'h00);
    chk("R7 write 1 keeps alarm", alarm, 1);
    do_kick;
    chk("R7 kick keeps alarm", alarm, 1);
    wr_ctl(1'b0, 1'b0, 1'b0, 5'h00);
    chk("R7 write 0 clears alarm", alarm, 0);
    chk("R8 strap again", fsel, STRAP);
    idle;

    // R2 sweep of reload values
    foreach (ns[i]) begin
      wr_cnt(8'(ns[i]));
      wr_ctl(1'b0, 1'b0, 1'b0, 5'(ns[i] + 7));
      strap_wd_en = 1'b1;
      wait_alarm(1000, n);
      chk($sformatf("R2 timeout N=%0d", ns[i]), n, ((ns[i] == 0) ? 1 : ns[i]) * DIV);
      chk("R8 safe code", fsel, ns[i] + 7);
      measure_low(w);
      chk("R9 width on expiry", w, RST);
      strap_wd_en = 1'b0;
      wr_ctl(1'b0, 1'b0, 1'b0, 5'(ns[i] + 7));
      idle;
    end

    // R5 reload write while running
    wr_cnt(8'd8);
    strap_wd_en = 1'b1;
    repeat (10) @(negedge clk);
    wr_cnt(8'd2);
    wait_alarm(1000, n);
    chk("R5 restart from write", n, 2 * DIV);
    strap_wd_en = 1'b0;
    wr_ctl(1'b0, 1'b0, 1'b0, 5'h00);
    idle;

    // R4 kick mid-count
    wr_cnt(8'd3);
    strap_wd_en = 1'b1;
    repeat (2 * DIV + 1) @(negedge clk);
    chk("R4 no alarm before kick", alarm, 0);
    do_kick;
    wait_alarm(1000, n);
    chk("R4 restart from kick", n, 3 * DIV);
    strap_wd_en = 1'b0;
    wr_ctl(1'b0, 1'b0, 1'b0, 5'h00);
    idle;

    // R6 enable sources
    wr_ctl(1'b0, 1'b1, 1'b0, 5'h15);
    repeat (10 * DIV) @(negedge clk);
    chk("R6 soft enable ignored without prog", alarm, 0);
    strap_wd_en = 1'b1;
    wr_ctl(1'b1, 1'b0, 1'b0, 5'h15);
    chk("R8 src reg", fsel_src, 1);
    repeat (10 * DIV) @(negedge clk);
    chk("R6 strap ignored with prog", alarm, 0);
    strap_wd_en = 1'b0;
    wr_ctl(1'b1, 1'b1, 1'b0, 5'h15);
    wait_alarm(1000, n);
    chk("R6 soft enable timeout", n, 3 * DIV);
    chk("R8 safe over reg", fsel, 5'h15);
    wr_ctl(1'b1, 1'b0, 1'b0, 5'h15);
    chk("R8 reg after clear", fsel_src, 1);
    idle;

    // R10 gear change pulses
    wr_frq(5'h13);
    chk("R10 no pulse same cycle", sys_rst_n, 1);
    chk("R8 fsel from reg", fsel, 5'h13);
    @(negedge clk);
    measure_low(w);
    chk("R10 change pulse width", w, RST);
    idle;
    wr_frq(5'h13);
    hi = 1;
    repeat (RST + 3) begin
      if (!sys_rst_n) hi = 0;
      @(negedge clk);
    end
    chk("R10 same value no pulse", hi, 1);
    frq_wdata = 5'h04; frq_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    frq_wdata = 5'h05;
    @(posedge clk); @(negedge clk);
    frq_wr = 1'b0;
    measure_low(w);
    chk("R9 back-to-back not extended", w, RST);
    chk("R10 final fsel", fsel, 5'h05);

    summary;
    $finish;
  end
endmodule